// File: doc/BRIEF.md
# Vertical-Sync Relative Line Interrupt Generator

This block raises two independent, programmable event pulses inside every vertical sync period of a video stream. After the chosen vertical sync edge it counts horizontal sync pulses. Each event fires when that line count reaches its own 15-bit threshold. A polarity input decides whether the rising or the falling vertical sync edge opens a new period. With interlaced, field-based video every field carries its own vertical sync, so each event fires once per field and therefore twice per frame.

Both sync inputs are sampled and edge-detected in the block clock domain. A line counter is cleared by the selected vertical edge, counts horizontal rising edges and stops at its maximum value. Each event stage compares the counter with its threshold and gives a one-cycle pulse, gated by a global enable. The interrupt status registers and the sync timing generator sit outside this block.

Top module: `vs_line_irq`

## Requirements
- R1: After reset both event outputs are low. Until the first selected vertical sync edge arrives, no horizontal sync pulse produces an event, whatever the thresholds are.
- R2: When `vs_pol_i` is 0 a rising edge of `vs_i` starts a new period and a falling edge is ignored. When it is 1 a falling edge starts the period and a rising edge is ignored.
- R3: `evt_a_o` pulses once when the count of `hs_i` rising edges since the period start equals `thr_a_i`. The pulse is high in the clock cycle after the second rising clock edge that follows the `hs_i` input edge.
- R4: `evt_b_o` behaves the same way against `thr_b_i`, independently of `evt_a_o`. Both can fire in the same period at different lines.
- R5: A threshold of zero fires its event on the vertical sync edge itself, two clock edges after the `vs_i` transition.
- R6: Each event is a single-cycle pulse and fires at most once per period. Every selected vertical sync edge restarts the count, so two fields give two pulses.
- R7: While `en_i` is low neither output pulses. The line counter still tracks the lines.
- R8: The line counter saturates at its maximum (2^LINE_W - 1) and never wraps. A period longer than the counter range therefore fires an event only once.
- R9: A horizontal sync edge in the same cycle as the selected vertical sync edge is not counted.
- R10: A threshold larger than the number of lines in the period produces no event in that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Global event enable |
| vs_pol_i | input | 1 | Period start edge: 0 = rising, 1 = falling |
| vs_i | input | 1 | Vertical sync |
| hs_i | input | 1 | Horizontal sync, counted on rising edges |
| thr_a_i | input | LINE_W (15) | Line threshold for event A |
| thr_b_i | input | LINE_W (15) | Line threshold for event B |
| evt_a_o | output | 1 | Event A pulse |
| evt_b_o | output | 1 | Event B pulse |

## Verification
The bench drives one vertical sync pulse held across several lines under both polarities. A design that restarts on the wrong edge reports event A three lines too late or three lines too early. A zero threshold, a threshold past the frame end, and a horizontal edge in the same cycle as the vertical edge are each tested. These expose designs that skip line zero, fire on stale counts, or count the coincident line. A second instance with a 3-bit counter runs a 20-line period. A wrapping counter would fire three times there instead of once, and back-to-back fields must give exactly two pulses.

// File: rtl/vli_pkg.sv
package vli_pkg;

    localparam int unsigned NUM_EVT = 2;

    typedef enum logic {
        VS_RISE = 1'b0,
        VS_FALL = 1'b1
    } vs_pol_e;

    typedef struct packed {
        logic vs_edge;
        logic hs_edge;
    } sync_evt_t;

    // Edge of interest between the current and previous sample of a sync line
    function automatic logic fn_sel_edge(input logic cur, input logic prv, input vs_pol_e pol);
        return (pol == VS_RISE) ? (cur & ~prv) : (~cur & prv);
    endfunction

endpackage

// File: rtl/vli_edge_det.sv
module vli_edge_det
    import vli_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  vs_pol_e   pol_i,
    input  logic      vs_i,
    input  logic      hs_i,
    output sync_evt_t evt_o
);
    // Sample registers load during reset as well, so once reset drops the
    // previous-sample stage already holds the true line level.
    logic vs_cur, vs_prv, hs_cur, hs_prv;
    logic valid_q;

    always_ff @(posedge clk) begin
        vs_cur <= vs_i;
        vs_prv <= vs_cur;
        hs_cur <= hs_i;
        hs_prv <= hs_cur;
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= 1'b1;
    end

    always_comb begin
        evt_o.vs_edge = valid_q & fn_sel_edge(vs_cur, vs_prv, pol_i);
        evt_o.hs_edge = valid_q & fn_sel_edge(hs_cur, hs_prv, VS_RISE);
    end

    // A rising edge needs a low sample first, so two edges never abut
    p_hs_edge_gap_r3: assert property (@(posedge clk) disable iff (rst)
        evt_o.hs_edge |=> !evt_o.hs_edge);

    p_vs_edge_gap_r2: assert property (@(posedge clk) disable iff (rst)
        evt_o.vs_edge && $stable(pol_i) |=> !evt_o.vs_edge || $changed(pol_i));

endmodule

// File: rtl/vli_line_ctr.sv
module vli_line_ctr
    import vli_pkg::*;
#(
    parameter int unsigned LINE_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  sync_evt_t         sync_i,
    output logic [LINE_W-1:0] line_d_o,
    output logic              adv_o
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    logic [LINE_W-1:0] line_q;
    logic              at_max;

    assign at_max = (line_q == LINE_MAX);

    // Vertical edge wins over a coincident horizontal edge
    always_comb begin
        if (sync_i.vs_edge)                line_d_o = '0;
        else if (sync_i.hs_edge && !at_max) line_d_o = line_q + LINE_W'(1);
        else                               line_d_o = line_q;
    end

    // A fresh count value (or a restart) is what the comparators act on
    assign adv_o = sync_i.vs_edge | (sync_i.hs_edge & ~at_max);

    // Reset to the saturated value: nothing matches until a period opens
    always_ff @(posedge clk) begin
        if (rst) line_q <= LINE_MAX;
        else     line_q <= line_d_o;
    end

    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        sync_i.vs_edge |=> line_q == '0);

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        at_max && !sync_i.vs_edge |=> line_q == LINE_MAX);

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        sync_i.hs_edge && !sync_i.vs_edge && !at_max
        |=> line_q == $past(line_q) + LINE_W'(1));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !sync_i.hs_edge && !sync_i.vs_edge |=> $stable(line_q));

endmodule

// File: rtl/vli_evt.sv
module vli_evt #(
    parameter int unsigned LINE_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              adv_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [LINE_W-1:0] thr_i,
    output logic              evt_o
);
    logic hit;

    assign hit = en_i & adv_i & (line_i == thr_i);

    always_ff @(posedge clk) begin
        if (rst) evt_o <= 1'b0;
        else     evt_o <= hit;
    end

    p_gated_r7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !evt_o);

    p_single_r6: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> !evt_o);

    p_needs_adv_r3: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> !evt_o);

endmodule

// File: rtl/vs_line_irq.sv
module vs_line_irq
    import vli_pkg::*;
#(
    parameter int unsigned LINE_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              vs_pol_i,
    input  logic              vs_i,
    input  logic              hs_i,
    input  logic [LINE_W-1:0] thr_a_i,
    input  logic [LINE_W-1:0] thr_b_i,
    output logic              evt_a_o,
    output logic              evt_b_o
);
    sync_evt_t         sync_evt;
    logic [LINE_W-1:0] line_d;
    logic              adv;
    logic [LINE_W-1:0] thr   [NUM_EVT];
    logic [NUM_EVT-1:0] evt;

    assign thr[0] = thr_a_i;
    assign thr[1] = thr_b_i;

    vli_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .pol_i (vs_pol_e'(vs_pol_i)),
        .vs_i  (vs_i),
        .hs_i  (hs_i),
        .evt_o (sync_evt)
    );

    vli_line_ctr #(.LINE_W(LINE_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .sync_i   (sync_evt),
        .line_d_o (line_d),
        .adv_o    (adv)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        vli_evt #(.LINE_W(LINE_W)) u_evt (
            .clk    (clk),
            .rst    (rst),
            .en_i   (en_i),
            .adv_i  (adv),
            .line_i (line_d),
            .thr_i  (thr[g]),
            .evt_o  (evt[g])
        );
    end

    assign evt_a_o = evt[0];
    assign evt_b_o = evt[1];

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> evt == '0);

endmodule

// File: tb/vs_line_irq_tb.sv
module vs_line_irq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic        pol = 1'b0;
    logic        vs = 1'b0;
    logic        hs = 1'b0;
    logic [14:0] thr_a = '0;
    logic [14:0] thr_b = '0;
    logic        evt_a, evt_b, sat_a, sat_b;

    int n_run = 0, n_fail = 0;
    int hs_n = 0;
    int na = 0, nb = 0, ns = 0, at_a = -1, at_b = -1;
    int wide = 0;
    logic pa = 1'b0, pb = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vs_line_irq u_dut (
        .clk(clk), .rst(rst), .en_i(en), .vs_pol_i(pol), .vs_i(vs), .hs_i(hs),
        .thr_a_i(thr_a), .thr_b_i(thr_b), .evt_a_o(evt_a), .evt_b_o(evt_b)
    );

    vs_line_irq #(.LINE_W(3)) u_sat (
        .clk(clk), .rst(rst), .en_i(en), .vs_pol_i(pol), .vs_i(vs), .hs_i(hs),
        .thr_a_i(thr_a[2:0]), .thr_b_i(thr_b[2:0]), .evt_a_o(sat_a), .evt_b_o(sat_b)
    );

    // Monitor just after each rising edge; stimulus moves only on falling edges
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (evt_a) begin na++; at_a = hs_n; end
            if (evt_b) begin nb++; at_b = hs_n; end
            if (sat_a) ns++;
            if ((evt_a && pa) || (evt_b && pb)) wide++;
            pa = evt_a;
            pb = evt_b;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clr_mon();
        na = 0; nb = 0; ns = 0; at_a = -1; at_b = -1; wide = 0;
    endtask

    task automatic line();
        @(negedge clk); hs = 1'b1; hs_n++;
        idle(2); hs = 1'b0;
        idle(3);
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) line();
    endtask

    // Selected edge first, trailing edge after three cycles, then lines
    task automatic frame(input int n);
        @(negedge clk); vs = ~vs; hs_n = 0;
        idle(3); vs = ~vs;
        lines(n);
        idle(4);
    endtask

    task automatic set_pol(input logic p);
        @(negedge clk); vs = p; idle(4);
        pol = p; idle(4); clr_mon();
    endtask

    task automatic t_reset();
        chk(int'(evt_a), 0, "R1 evt_a after reset");
        chk(int'(evt_b), 0, "R1 evt_b after reset");
        thr_a = 15'd1; thr_b = 15'd2; clr_mon(); hs_n = 0;
        lines(4); idle(4);
        chk(na + nb, 0, "R1 lines before first vertical edge");
    endtask

    task automatic t_basic();
        set_pol(1'b0);
        thr_a = 15'd5; thr_b = 15'd2;
        frame(8);
        chk(na, 1, "R3 evt_a count"); chk(at_a, 5, "R3 evt_a line");
        chk(nb, 1, "R4 evt_b count"); chk(at_b, 2, "R4 evt_b line");
        chk(wide, 0, "R6 single-cycle pulses");
    endtask

    task automatic t_polarity(input logic p, input int exp_line);
        set_pol(p);
        vs = 1'b1; idle(2);
        thr_a = 15'd4; thr_b = 15'd30;
        clr_mon();
        @(negedge clk); vs = 1'b0; hs_n = 0;
        lines(3);
        @(negedge clk); vs = 1'b1;
        lines(5); idle(4);
        chk(na, 1, "R2 one event per period");
        chk(at_a, exp_line, "R2 start edge follows polarity");
        vs = p; idle(4);
    endtask

    task automatic t_zero();
        set_pol(1'b0);
        thr_a = 15'd0; thr_b = 15'd3;
        frame(4);
        chk(na, 1, "R5 zero threshold count");
        chk(at_a, 0, "R5 zero threshold on vertical edge");
        chk(at_b, 3, "R4 other threshold unaffected");
    endtask

    task automatic t_fields();
        set_pol(1'b0);
        thr_a = 15'd2; thr_b = 15'd4;
        frame(5); frame(5);
        chk(na, 2, "R6 evt_a once per field");
        chk(nb, 2, "R6 evt_b once per field");
    endtask

    task automatic t_enable();
        set_pol(1'b0);
        en = 1'b0; thr_a = 15'd1; thr_b = 15'd0;
        frame(3);
        chk(na + nb, 0, "R7 no events when disabled");
        en = 1'b1;
    endtask

    task automatic t_sat();
        set_pol(1'b0);
        thr_a = 15'd2; thr_b = 15'd30;
        frame(20);
        chk(ns, 1, "R8 saturating counter fires once");
        chk(na, 1, "R8 wide counter fires once");
    endtask

    task automatic t_coincide();
        set_pol(1'b0);
        thr_a = 15'd1; thr_b = 15'd30;
        @(negedge clk); vs = 1'b1; hs = 1'b1; hs_n = 1;
        idle(2); hs = 1'b0; idle(1); vs = 1'b0; idle(2);
        lines(2); idle(4);
        chk(na, 1, "R9 coincident line count");
        chk(at_a, 2, "R9 coincident line not counted");
    endtask

    task automatic t_beyond();
        set_pol(1'b0);
        thr_a = 15'd20; thr_b = 15'd11;
        frame(10);
        chk(na + nb, 0, "R10 threshold beyond period");
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_basic();
        t_polarity(1'b1, 4);
        t_polarity(1'b0, 7);
        t_zero();
        t_fields();
        t_enable();
        t_sat();
        t_coincide();
        t_beyond();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule